// File: doc/BRIEF.md
# I2C Bus Condition and Hang Monitor

This block listens to the clock and data lines of an I2C bus without ever driving them. Both lines pass through a two-stage synchroniser. The block compares each synchronised sample with the one taken a cycle earlier, which lets it recognise START, repeated START and STOP. It keeps a bus-busy indication that follows those conditions. It also raises sticky start and stop flags. Software clears each flag by pulsing a write-one-to-clear strobe. An interrupt request combines each flag with its own enable.

A free-running sample tick clocks a 4-bit hang counter. The counter advances while the clock line is high and restarts on every clock falling edge. If it wraps while the data line is held low, the bus is reported as hung. Only the next START clears that report. The hang flag has no interrupt of its own.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, bus_busy, start_flag, stop_flag, hang_flag and irq are all 0. The idle bus, with both lines high, never asserts bus_busy.
- R2: A START is SDA falling while SCL stays high, judged on synchronised samples. It sets bus_busy. A STOP is SDA rising while SCL stays high. It clears bus_busy.
- R3: start_flag is set by every START, including a repeated START while the bus is already busy. It stays set until a one-cycle pulse on clr_start.
- R4: stop_flag is set by every STOP and stays set until a one-cycle pulse on clr_stop.
- R5: An SDA change while SCL is low, and an SCL change of either direction, set neither flag and leave bus_busy unchanged.
- R6: The hang counter advances only in cycles where samp_tick is 1 and SCL is high. With samp_tick held at 0, hang_flag never sets.
- R7: When the counter wraps from 15 to 0 with SDA low, hang_flag is set; this happens on the 16th counted tick. A wrap with SDA high leaves hang_flag at 0.
- R8: A falling edge on SCL resets the hang counter to 0. SCL high phases shorter than 16 ticks therefore never set hang_flag.
- R9: hang_flag is cleared only by a START. A STOP, clr_start and clr_stop leave it set.
- R10: irq is 1 exactly when (start_flag AND start_ien) OR (stop_flag AND stop_ien) held on the previous cycle. It stays 1 until the contributing flag is cleared or its enable is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| samp_tick | input | 1 | Sample-clock enable for the hang counter |
| start_ien | input | 1 | Interrupt enable for start_flag |
| stop_ien | input | 1 | Interrupt enable for stop_flag |
| clr_start | input | 1 | Write-one-to-clear strobe for start_flag |
| clr_stop | input | 1 | Write-one-to-clear strobe for stop_flag |
| bus_busy | output | 1 | Bus is between a START and a STOP |
| start_flag | output | 1 | Sticky START / repeated START flag |
| stop_flag | output | 1 | Sticky STOP flag |
| hang_flag | output | 1 | Bus hang detected |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench drives sequences that contain the easily confused cases.

- Data edges while SCL is low must not be taken for conditions. A design that ignored SCL would toggle busy and the flags there.
- A repeated START in the middle of a transfer must still set start_flag. A design that only looked for START while idle would miss it.
- SCL rising while SDA is low must not count as a condition. A detector that compared only the current samples, without the previous ones, would report one.
- On the hang side, SCL is toggled every few ticks to show that the counter really restarts. With samp_tick held low, the counter must stay frozen.
- A STOP must leave hang_flag set until the following START. A design that cleared it on STOP or on a flag-clear strobe would lose the report.

// File: rtl/i2c_watch_pkg.sv
package i2c_watch_pkg;

    // Events seen by the condition detector in one cycle
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_fall;
    } bus_evt_t;

    // Registered status of the top level
    typedef struct packed {
        logic busy;
        logic start_f;
        logic stop_f;
        logic irq;
    } watch_state_t;

endpackage

// File: rtl/i2c_watch_sync.sv
module i2c_watch_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[g]};
        end

        // Reset to 1: an idle bus is high, so no false edge after reset
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[LAST];
    end
endmodule

// File: rtl/i2c_watch_cond.sv
module i2c_watch_cond
    import i2c_watch_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;

    always_comb begin
        scl_prev_d     = scl_i;
        sda_prev_d     = sda_i;
        evt_o.start    = scl_prev_q &  scl_i &  sda_prev_q & ~sda_i;
        evt_o.stop     = scl_prev_q &  scl_i & ~sda_prev_q &  sda_i;
        evt_o.scl_fall = scl_prev_q & ~scl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    // R5: a condition is never reported in a cycle where SCL moved
    a_r5_no_cond_on_scl_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i != scl_prev_q) |-> !(evt_o.start || evt_o.stop));
endmodule

// File: rtl/i2c_watch_hang.sv
module i2c_watch_hang #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic scl_fall_i,
    input  logic start_i,
    input  logic tick_i,
    output logic hang_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hang;
    } hang_state_t;

    hang_state_t st_d, st_q;
    logic        wrap;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (scl_fall_i) begin
            st_d.cnt = '0;
        end else if (scl_i && tick_i) begin
            wrap     = (st_q.cnt == CNT_MAX);
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (start_i)            st_d.hang = 1'b0;
        else if (wrap && !sda_i) st_d.hang = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hang_o = st_q.hang;

    // R8: counter restarts on SCL fall
    a_r8_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall_i |=> (st_q.cnt == '0));
    // R6: without a tick the counter holds
    a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !scl_fall_i) |=> $stable(st_q.cnt));
    // R9: START clears the hang report
    a_r9_hang_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !hang_o);
    // R7: hang only rises with the line low
    a_r7_hang_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hang_o) |-> ($past(!sda_i) && $past(scl_i)));
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2c_watch_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HANG_CNT_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic samp_tick,
    input  logic start_ien,
    input  logic stop_ien,
    input  logic clr_start,
    input  logic clr_stop,
    output logic bus_busy,
    output logic start_flag,
    output logic stop_flag,
    output logic hang_flag,
    output logic irq
);
    localparam int LINES = 2;

    logic [LINES-1:0] lines_s;
    bus_evt_t         evt;
    watch_state_t     st_d, st_q;

    i2c_watch_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_in, sda_in}),
        .sync_o (lines_s)
    );

    i2c_watch_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (lines_s[1]),
        .sda_i (lines_s[0]),
        .evt_o (evt)
    );

    i2c_watch_hang #(.CNT_W(HANG_CNT_W)) u_hang (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (lines_s[1]),
        .sda_i      (lines_s[0]),
        .scl_fall_i (evt.scl_fall),
        .start_i    (evt.start),
        .tick_i     (samp_tick),
        .hang_o     (hang_flag)
    );

    always_comb begin
        st_d = st_q;
        if (evt.start)     st_d.busy = 1'b1;
        else if (evt.stop) st_d.busy = 1'b0;
        // A new event wins over a clear strobe in the same cycle
        if (evt.start)      st_d.start_f = 1'b1;
        else if (clr_start) st_d.start_f = 1'b0;
        if (evt.stop)       st_d.stop_f = 1'b1;
        else if (clr_stop)  st_d.stop_f = 1'b0;
        st_d.irq = (st_q.start_f & start_ien) | (st_q.stop_f & stop_ien);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_busy   = st_q.busy;
    assign start_flag = st_q.start_f;
    assign stop_flag  = st_q.stop_f;
    assign irq        = st_q.irq;

    // R2: START makes the bus busy, STOP frees it
    a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        evt.start |=> bus_busy);
    a_r2_idle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        evt.stop |=> !bus_busy);
    // R3: start_flag only rises from a detected START
    a_r3_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_flag) |-> $past(evt.start));
    // R4: stop_flag holds until its strobe
    a_r4_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && !clr_stop) |=> stop_flag);
    // R10: a raised request never appears without an enabled flag
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((start_flag && start_ien) || (stop_flag && stop_ien)));
endmodule

// File: tb/test_i2c_bus_watch.sv
module test_i2c_bus_watch;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, samp_tick = 1'b0;
    logic start_ien = 1'b0, stop_ien = 1'b0, clr_start = 1'b0, clr_stop = 1'b0;
    logic bus_busy, start_flag, stop_flag, hang_flag, irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_bus_watch i_i2c_bus_watch (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .samp_tick(samp_tick), .start_ien(start_ien), .stop_ien(stop_ien),
        .clr_start(clr_start), .clr_stop(clr_stop), .bus_busy(bus_busy),
        .start_flag(start_flag), .stop_flag(stop_flag), .hang_flag(hang_flag),
        .irq(irq)
    );

    // {scl, sda, expected busy, expected start_flag, expected stop_flag}
    localparam int NVEC = 13;
    localparam logic [4:0] VEC [NVEC] = '{
        5'b11_000,  // idle
        5'b10_110,  // START
        5'b00_100,  // SCL low
        5'b01_100,  // SDA rises with SCL low: nothing
        5'b11_100,  // SCL rises
        5'b10_110,  // repeated START
        5'b00_100,
        5'b10_100,  // SCL rises with SDA low: nothing
        5'b11_001,  // STOP
        5'b01_000,
        5'b00_000,  // SDA falls with SCL low: nothing
        5'b10_000,  // SCL rises, SDA low: nothing
        5'b11_001   // STOP again
    };

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        clr_start = 1'b1; clr_stop = 1'b1;
        wait_cyc(1);
        clr_start = 1'b0; clr_stop = 1'b0;
        wait_cyc(1);
    endtask

    task automatic lines(input logic scl, input logic sda);
        scl_in = scl; sda_in = sda;
        wait_cyc(5);
    endtask

    initial begin
        wait_cyc(3);
        check("R1 busy at reset", bus_busy, 1'b0);
        check("R1 start_flag at reset", start_flag, 1'b0);
        rst_n = 1'b1;
        wait_cyc(5);
        check("R1 busy idle", bus_busy, 1'b0);
        check("R1 stop_flag", stop_flag, 1'b0);
        check("R1 hang_flag", hang_flag, 1'b0);
        check("R1 irq", irq, 1'b0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            lines(VEC[v][4], VEC[v][3]);
            check("R2 busy table", bus_busy, VEC[v][2]);
            check("R3 start_flag table", start_flag, VEC[v][1]);
            check("R4 stop_flag table", stop_flag, VEC[v][0]);
            check("R6 no hang without tick", hang_flag, 1'b0);
            clear_flags();
        end

        // R3: flag sticky until strobe
        lines(1, 0);
        wait_cyc(20);
        check("R3 start_flag sticky", start_flag, 1'b1);
        clr_stop = 1'b1; wait_cyc(1); clr_stop = 1'b0; wait_cyc(1);
        check("R3 clr_stop leaves start_flag", start_flag, 1'b1);

        // R10: interrupt gating
        check("R10 irq disabled", irq, 1'b0);
        start_ien = 1'b1; wait_cyc(2);
        check("R10 irq on enabled start", irq, 1'b1);
        wait_cyc(10);
        check("R10 irq held", irq, 1'b1);
        start_ien = 1'b0; wait_cyc(2);
        check("R10 irq drops with enable", irq, 1'b0);
        start_ien = 1'b1; wait_cyc(2);
        clr_start = 1'b1; wait_cyc(1); clr_start = 1'b0; wait_cyc(2);
        check("R3 clr_start clears", start_flag, 1'b0);
        check("R10 irq drops after clear", irq, 1'b0);
        start_ien = 1'b0;

        // R6: SCL high, SDA low, no tick for long: no hang
        wait_cyc(60);
        check("R6 frozen counter", hang_flag, 1'b0);

        // R8: SCL toggles every few ticks, SDA low: no hang
        samp_tick = 1'b1;
        for (int k = 0; k < 8; k++) begin
            scl_in = 1'b0; wait_cyc(4);
            scl_in = 1'b1; wait_cyc(10);
        end
        check("R8 short high phases", hang_flag, 1'b0);

        // R7: SCL held high with SDA low: hang after 16 ticks
        wait_cyc(20);
        check("R7 hang set", hang_flag, 1'b1);

        // R9: STOP and strobes leave hang set
        samp_tick = 1'b0;
        clear_flags();
        check("R9 strobes keep hang", hang_flag, 1'b1);
        stop_ien = 1'b1;
        lines(1, 1);
        check("R4 STOP seen", stop_flag, 1'b1);
        check("R9 STOP keeps hang", hang_flag, 1'b1);
        check("R10 stop irq", irq, 1'b1);
        clr_stop = 1'b1; wait_cyc(1); clr_stop = 1'b0; wait_cyc(2);
        check("R10 stop irq cleared", irq, 1'b0);
        stop_ien = 1'b0;
        lines(1, 0);
        check("R9 START clears hang", hang_flag, 1'b0);
        check("R2 busy after START", bus_busy, 1'b1);

        // R7: wrap with SDA high does not hang
        lines(0, 0);
        lines(0, 1);
        samp_tick = 1'b1;
        lines(1, 1);
        wait_cyc(40);
        check("R7 no hang with SDA high", hang_flag, 1'b0);
        samp_tick = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(200000);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule